// File: doc/BRIEF.md
# Two-Bank Latched Interrupt Controller

This block gathers sixteen interrupt request lines into two byte-wide banks and presents them to a processor through a small synchronous byte bus. Bank A carries sources 0 to 7 and bank B carries sources 8 to 15, so the 16-bit source index maps to bank A in the low byte and bank B in the high byte. Every external line first passes through a two-flop synchroniser. A level source shows its synchronised input directly. An edge source, which includes a frame-flyback line, a ring-indicate line and the two timer underflow pulses, sets a sticky bit on each rising edge. That bit stays set until software writes a one to its position in the bank A clear register.

For each bank, software can read a raw status byte, whatever the mask says, and a masked request byte. It can also read and write a mask byte. The interrupt output goes high whenever any masked request is set in either bank. A separate fast-interrupt mask selects bank A status bits onto a second output. After reset every mask is zero, so both outputs are held low until software enables sources.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, the three mask registers read 0x00, every edge latch is clear, and irq_o and fiq_o are low.
- R2: Status register A (address 0x0) bit n reports source n for n = 0..7. Status register B (address 0x4) bit n reports source n+8. Status reads are unaffected by any mask.
- R3: A level source is shown in status exactly two clock edges after its input changes: it is not yet visible after one edge, and it is visible after two.
- R4: Sources 2, 3, 5 and 6 of bank A are edge sources. A rising input, including a pulse only one cycle wide, sets the status bit three edges later, and the bit stays set after the input falls.
- R5: Writing a byte to the clear register (address 0x3) clears every edge latch whose bit is 1 in that byte. Bits written as 0 are unaffected, level bits are unaffected, and the register reads as 0x00.
- R6: When a rising edge would set a latch in the same cycle as a clear of that bit, the latch stays set.
- R7: The masked request registers A (address 0x1) and B (address 0x5) read as that bank's status AND its mask.
- R8: irq_o is high exactly when either masked request register is non-zero.
- R9: fiq_o is high exactly when status A AND the fast mask (address 0x8) is non-zero. Address 0x9 reads that AND.
- R10: Mask A (address 0x2), mask B (address 0x6) and the fast mask read back the last value written. With all three masks at 0x00, irq_o and fiq_o stay low whatever the sources do.
- R11: Reads of unmapped addresses (0x7 and 0xA to 0xF) return 0x00. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Asynchronous request lines; bits 7:0 bank A, 15:8 bank B |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Active-high interrupt request |
| fiq_o | output | 1 | Active-high fast interrupt request |

## Verification
A table of level-only source patterns is combined with different mask values. Some patterns set bits in both banks with disjoint masks, which separates a status/mask mix-up from a bank swap. Others have status bits only where the mask is zero, so irq_o must stay low, which exposes an OR taken over raw status instead of masked requests. Directed tests then cover the timing. They hold a level input for one edge and then two, to pin the synchroniser depth. They send one-cycle pulses on the timer bits, clear with partial masks, and line a rising edge up with a clear write in the same cycle, to check that the edge wins.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [3:0] ADR_STAT_A = 4'h0;
  localparam logic [3:0] ADR_PEND_A = 4'h1;
  localparam logic [3:0] ADR_MASK_A = 4'h2;
  localparam logic [3:0] ADR_CLR_A  = 4'h3;
  localparam logic [3:0] ADR_STAT_B = 4'h4;
  localparam logic [3:0] ADR_PEND_B = 4'h5;
  localparam logic [3:0] ADR_MASK_B = 4'h6;
  localparam logic [3:0] ADR_FMASK  = 4'h8;
  localparam logic [3:0] ADR_FPEND  = 4'h9;

  // masked request of one bank
  function automatic logic [BYTE_W-1:0] pend_f(input logic [BYTE_W-1:0] stat,
                                               input logic [BYTE_W-1:0] mask);
    return stat & mask;
  endfunction

  // next value of an edge latch: a new edge outranks a clear
  function automatic logic latch_next_f(input logic cur, input logic rise,
                                        input logic clr);
    return rise | (cur & ~clr);
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] meta_o,
  output logic [W-1:0] sync_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_o <= '0;
      sync_o <= '0;
    end else begin
      meta_o <= async_i;
      sync_o <= meta_o;
    end
  end
endmodule

// File: rtl/intc_edge_bank.sv
module intc_edge_bank #(
  parameter int unsigned    W         = 8,
  parameter logic [W-1:0]   EDGE_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] stat_o
);
  import intc_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q, held_q;
      assign rise_o[i] = lvl_i[i] & ~prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          held_q <= 1'b0;
        end else begin
          prev_q <= lvl_i[i];
          held_q <= latch_next_f(held_q, rise_o[i], clr_i[i]);
        end
      end
      assign stat_o[i] = held_q;
    end else begin : g_level
      assign rise_o[i] = 1'b0;
      assign stat_o[i] = lvl_i[i];
    end
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter logic [7:0]  EDGE_A = 8'h6C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       src_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  import intc_pkg::*;

  localparam int unsigned NSRC = 2 * BANK_W;

  logic [NSRC-1:0]   meta, lvl;
  logic [BANK_W-1:0] stat_a, stat_b, rise_a, rise_b, clr_a;
  logic [BANK_W-1:0] mask_a, mask_b, fmask;
  logic [BANK_W-1:0] pend_a, pend_b, fpend;
  logic              wr_stb;

  intc_sync #(.W(NSRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(src_i),
    .meta_o(meta), .sync_o(lvl)
  );

  assign wr_stb = bus_sel_i & bus_we_i;
  assign clr_a  = (wr_stb && bus_addr_i == ADR_CLR_A) ? bus_wdata_i : '0;

  intc_edge_bank #(.W(BANK_W), .EDGE_MASK(EDGE_A)) u_bank_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl[BANK_W-1:0]),
    .clr_i(clr_a), .rise_o(rise_a), .stat_o(stat_a)
  );

  intc_edge_bank #(.W(BANK_W), .EDGE_MASK('0)) u_bank_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl[NSRC-1:BANK_W]),
    .clr_i('0), .rise_o(rise_b), .stat_o(stat_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_a <= '0;
      mask_b <= '0;
      fmask  <= '0;
    end else if (wr_stb) begin
      case (bus_addr_i)
        ADR_MASK_A: mask_a <= bus_wdata_i;
        ADR_MASK_B: mask_b <= bus_wdata_i;
        ADR_FMASK:  fmask  <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  assign pend_a = pend_f(stat_a, mask_a);
  assign pend_b = pend_f(stat_b, mask_b);
  assign fpend  = pend_f(stat_a, fmask);
  assign irq_o  = |{pend_a, pend_b};
  assign fiq_o  = |fpend;

  always_comb begin
    case (bus_addr_i)
      ADR_STAT_A: bus_rdata_o = stat_a;
      ADR_PEND_A: bus_rdata_o = pend_a;
      ADR_MASK_A: bus_rdata_o = mask_a;
      ADR_STAT_B: bus_rdata_o = stat_b;
      ADR_PEND_B: bus_rdata_o = pend_b;
      ADR_MASK_B: bus_rdata_o = mask_b;
      ADR_FMASK:  bus_rdata_o = fmask;
      ADR_FPEND:  bus_rdata_o = fpend;
      default:    bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter logic [7:0] EDGE_A = 8'h6C
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] stat_a,
  input logic [7:0] stat_b,
  input logic [7:0] rise_a,
  input logic [7:0] clr_a,
  input logic [7:0] meta_b,
  input logic [7:0] mask_a,
  input logic [7:0] mask_b,
  input logic [7:0] fmask,
  input logic       irq_o,
  input logic       fiq_o
);
  // R4: a latched edge bit that is not cleared stays set
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat_a & EDGE_A & ~clr_a) & ~stat_a) == 8'h00));

  // R5: a clear with no coincident edge empties the bit
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_a & EDGE_A & $past(clr_a & ~rise_a)) == 8'h00));

  // R6: an edge arriving with a clear wins
  a_r6_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rise_a & clr_a) != 8'h00) |=> ((stat_a & $past(rise_a & clr_a)) == $past(rise_a & clr_a)));

  // R3: bank B level status is the synchroniser's first stage one edge later
  a_r3_level_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stat_b == $past(meta_b)));

  // R10: zero masks keep both outputs low
  a_r10_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_a == 8'h00 && mask_b == 8'h00) |-> !irq_o);
  a_r10_fiq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmask == 8'h00) |-> !fiq_o);
endmodule

bind dual_bank_intc intc_checker #(.EDGE_A(EDGE_A)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stat_a(stat_a), .stat_b(stat_b),
  .rise_a(rise_a), .clr_a(clr_a), .meta_b(meta[15:8]),
  .mask_a(mask_a), .mask_b(mask_b), .fmask(fmask),
  .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/tb_dual_bank_intc.sv
module tb_dual_bank_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq, fiq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_bank_intc dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  // {src, mask_a, mask_b, fmask, stat_a, stat_b, pend_a, pend_b, irq, fiq}
  typedef struct packed {
    logic [15:0] s;
    logic [7:0]  ma, mb, fm, xsa, xsb, xpa, xpb;
    logic        xi, xf;
  } vec_t;
  localparam int NV = 5;
  localparam vec_t VT [NV] = '{
    '{16'h0000, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0},
    '{16'h8001, 8'h01, 8'h00, 8'h00, 8'h01, 8'h80, 8'h01, 8'h00, 1'b1, 1'b0},
    '{16'h0190, 8'h01, 8'h80, 8'h10, 8'h90, 8'h01, 8'h00, 8'h00, 1'b0, 1'b1},
    '{16'hFF93, 8'h00, 8'h0F, 8'h02, 8'h93, 8'hFF, 8'h00, 8'h0F, 1'b1, 1'b1},
    '{16'h0082, 8'hFF, 8'hFF, 8'h00, 8'h82, 8'h00, 8'h82, 8'h00, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    cyc(2);
    // R1 reset state
    bus_rd(4'h2, r); chk("R1 mask_a", r, 8'h00);
    bus_rd(4'h6, r); chk("R1 mask_b", r, 8'h00);
    bus_rd(4'h8, r); chk("R1 fmask", r, 8'h00);
    bus_rd(4'h0, r); chk("R1 stat_a", r, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 fiq", {7'd0, fiq}, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    cyc(1);

    // table: level-only patterns (R2, R7, R8, R9, R10)
    for (int k = 0; k < NV; k++) begin
      bus_wr(4'h2, VT[k].ma);
      bus_wr(4'h6, VT[k].mb);
      bus_wr(4'h8, VT[k].fm);
      src = VT[k].s;
      cyc(3);
      bus_rd(4'h0, r); chk("R2 stat_a", r, VT[k].xsa);
      bus_rd(4'h4, r); chk("R2 stat_b", r, VT[k].xsb);
      bus_rd(4'h1, r); chk("R7 pend_a", r, VT[k].xpa);
      bus_rd(4'h5, r); chk("R7 pend_b", r, VT[k].xpb);
      bus_rd(4'h9, r); chk("R9 fpend", r, VT[k].xsa & VT[k].fm);
      bus_rd(4'h2, r); chk("R10 mask_a rb", r, VT[k].ma);
      bus_rd(4'h6, r); chk("R10 mask_b rb", r, VT[k].mb);
      chk("R8 irq", {7'd0, irq}, {7'd0, VT[k].xi});
      chk("R9 fiq", {7'd0, fiq}, {7'd0, VT[k].xf});
    end

    // R11 unmapped
    bus_wr(4'h7, 8'h55);
    bus_wr(4'hC, 8'hAA);
    bus_rd(4'h7, r); chk("R11 rd 7", r, 8'h00);
    bus_rd(4'hF, r); chk("R11 rd F", r, 8'h00);
    bus_rd(4'h2, r); chk("R11 mask_a kept", r, 8'hFF);
    bus_rd(4'h6, r); chk("R11 mask_b kept", r, 8'hFF);
    bus_rd(4'h8, r); chk("R11 fmask kept", r, 8'h00);

    // R10 zero masks block outputs while sources are active
    bus_wr(4'h2, 8'h00); bus_wr(4'h6, 8'h00);
    src = 16'hFF93; cyc(3);
    chk("R10 irq off", {7'd0, irq}, 8'h00);
    chk("R10 fiq off", {7'd0, fiq}, 8'h00);
    src = 16'h0000; cyc(3);

    // R3 two-edge latency on a level source
    src[0] = 1'b1;
    cyc(1); bus_rd(4'h0, r); chk("R3 after 1 edge", r & 8'h01, 8'h00);
    cyc(1); bus_rd(4'h0, r); chk("R3 after 2 edges", r & 8'h01, 8'h01);

    // R5 clear does not touch a level bit
    bus_wr(4'h3, 8'h01);
    bus_rd(4'h0, r); chk("R5 level kept", r & 8'h01, 8'h01);
    bus_rd(4'h3, r); chk("R5 clr reads 0", r, 8'h00);
    src[0] = 1'b0; cyc(3);

    // R4 edge latch on source 2, held after input falls
    src[2] = 1'b1; cyc(2);
    bus_rd(4'h0, r); chk("R4 not yet", r & 8'h04, 8'h00);
    cyc(1);
    bus_rd(4'h0, r); chk("R4 latched", r & 8'h04, 8'h04);
    src[2] = 1'b0; cyc(4);
    bus_rd(4'h0, r); chk("R4 held", r & 8'h04, 8'h04);

    // R4 one-cycle timer pulses on 5 and 6
    src[5] = 1'b1; cyc(1); src[5] = 1'b0; cyc(4);
    bus_rd(4'h0, r); chk("R4 timer0 pulse", r, 8'h24);
    src[6] = 1'b1; cyc(1); src[6] = 1'b0; cyc(4);
    bus_rd(4'h0, r); chk("R4 timer1 pulse", r, 8'h64);

    // R5 partial clears
    bus_wr(4'h3, 8'h00);
    bus_rd(4'h0, r); chk("R5 clear zero", r, 8'h64);
    bus_wr(4'h3, 8'h24);
    bus_rd(4'h0, r); chk("R5 clear 2,5", r, 8'h40);
    bus_wr(4'h3, 8'hFF);
    bus_rd(4'h0, r); chk("R5 clear all", r, 8'h00);

    // R6 edge coinciding with clear
    src[3] = 1'b1;
    cyc(1);
    bus_wr(4'h3, 8'h08);
    bus_rd(4'h0, r); chk("R6 edge wins", r & 8'h08, 8'h08);
    bus_wr(4'h3, 8'h08);
    bus_rd(4'h0, r); chk("R6 later clear", r & 8'h08, 8'h00);
    src[3] = 1'b0; cyc(2);

    // R8 edge bit raises irq through mask
    bus_wr(4'h2, 8'h08);
    src[3] = 1'b1; cyc(4);
    chk("R8 irq edge", {7'd0, irq}, 8'h01);
    bus_wr(4'h3, 8'h08);
    chk("R8 irq drop", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule